// File: doc/BRIEF.md
# Register-Offset Prefetch Address Unit

This unit decodes a register-offset instruction-prefetch hint and produces the address to prefetch. It accepts one 32-bit instruction word per clock, together with a mode bit that selects the fixed 32-bit encoding or the mixed-length encoding. It also takes the base and index register values, the carry flag and a condition-pass signal. It checks the word against the pattern for the selected mode and extracts the register numbers, the direction, the shift kind and the shift amount. It then shifts the index and adds it to the base or subtracts it from the base.

Every output is registered, so results appear one clock after the inputs. A legal word raises a one-cycle hint strobe and presents the target address. An index register number of 15 raises an unpredictable flag. A mixed-length word whose base register number is 15 belongs to the literal form: the unit raises a redirect flag for it and issues no hint. Register-file reads, the cache action and pipeline control are handled outside this unit.

Top module: `pfx_addr_gen`

## Requirements
- R1: In fixed mode (`narrow_mode_i`=0), a word matching `1111_0110_u101_nnnn_xxxx_aaaaa_tt_0_mmmm` with Rm≠15 and `cond_ok_i`=1 makes `hint_vld_o`=1 on the next clock. `target_o` then holds base ± shifted index. Bits 15:12 are ignored. When any of these conditions fails, no hint is issued.
- R2: Fixed-mode shift kind `tt` (bits 6:5) selects 00 = logical left by `aaaaa`, 01 = logical right and 10 = arithmetic right. For 01 and 10 an `aaaaa` (bits 11:7) of 0 means a shift of 32: logical right then gives 0, and arithmetic right gives 32 copies of index bit 31.
- R3: Fixed-mode `tt`=11 rotates the index right by `aaaaa` when `aaaaa`≠0. When `aaaaa`=0 the offset is instead `{carry_i, index[31:1]}`.
- R4: The fixed-mode bit `u` (bit 23) selects base + offset when 1 and base − offset when 0. The result wraps modulo 2^32.
- R5: In mixed-length mode (`narrow_mode_i`=1), a word matching `1111_1001_0001_nnnn_1111_000000_ii_mmmm` with Rn≠15 always adds. Its offset is the index shifted left by `ii` (bits 5:4, value 0 to 3).
- R6: In mixed-length mode, a matching word with Rn=15 sets `lit_redirect_o`=1 on the next clock and keeps `hint_vld_o`=0, whatever the value of `cond_ok_i`.
- R7: A matching word with Rm=15 (bits 3:0) sets `unpred_o`=1 on the next clock in either mode, whatever the value of `cond_ok_i`. No hint is issued for it.
- R8: A matching legal word with `cond_ok_i`=0 gives `hint_vld_o`=0 and `target_o`=0.
- R9: A word that does not match the pattern of the current mode drives all four outputs to 0 on the next clock. This covers a word of the other mode, fixed-mode bit 4 set, and mixed-length bits 11:6 nonzero.
- R10: While `rst_ni` is low, all outputs are 0. `target_o` is 0 in every cycle in which `hint_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| narrow_mode_i | input | 1 | 1 = mixed-length encoding, 0 = fixed 32-bit encoding |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| carry_i | input | 1 | Carry flag, used by rotate-with-extend |
| cond_ok_i | input | 1 | Condition passed |
| hint_vld_o | output | 1 | Prefetch hint strobe |
| target_o | output | 32 | Prefetch target address |
| unpred_o | output | 1 | Index register number 15 was used |
| lit_redirect_o | output | 1 | Word belongs to the literal form |

## Verification
The assertions check properties that must hold on every cycle. A hint never coincides with a redirect or an unpredictable flag. The target is zero whenever there is no hint. Every hint traces back to a passed condition. A redirect traces back to mixed-length mode. Only the bench sweeps can show that the address value is correct. They cover every shift kind, every amount, both directions and both carry values on operands that wrap, and the shift-by-32 and rotate-with-extend corners. They also cover the decode rejections.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_op_e;

  typedef struct packed {
    logic      match;
    logic      literal;
    logic      unpred;
    logic      add;
    logic [3:0] rn;
    logic [3:0] rm;
    shift_op_e op;
  } dec_t;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [31:0]      insn_i,
  input  logic             narrow_mode_i,
  output dec_t             dec_o,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic wide_hit, narrow_hit;
  logic [4:0] imm5;

  assign wide_hit   = (insn_i[31:24] == 8'hF6) && (insn_i[22:20] == 3'b101) && !insn_i[4];
  assign narrow_hit = (insn_i[31:20] == 12'hF91) && (insn_i[15:12] == 4'hF) &&
                      (insn_i[11:6] == 6'd0);
  assign imm5       = insn_i[11:7];

  always_comb begin
    dec_o    = '0;
    dec_o.op = SH_LSL;
    amt_o    = '0;
    dec_o.rn = insn_i[19:16];
    dec_o.rm = insn_i[3:0];
    if (!narrow_mode_i) begin
      if (wide_hit) begin
        dec_o.match = 1'b1;
        dec_o.add   = insn_i[23];
        unique case (insn_i[6:5])
          2'b00: begin dec_o.op = SH_LSL; amt_o = AMT_W'(imm5); end
          2'b01: begin dec_o.op = SH_LSR; amt_o = (imm5 == 5'd0) ? FULL : AMT_W'(imm5); end
          2'b10: begin dec_o.op = SH_ASR; amt_o = (imm5 == 5'd0) ? FULL : AMT_W'(imm5); end
          default: begin
            dec_o.op = (imm5 == 5'd0) ? SH_RRX : SH_ROR;
            amt_o    = AMT_W'(imm5);
          end
        endcase
      end
    end else if (narrow_hit) begin
      if (insn_i[19:16] == 4'hF) begin
        dec_o.literal = 1'b1;
      end else begin
        dec_o.match = 1'b1;
        dec_o.add   = 1'b1;
        dec_o.op    = SH_LSL;
        amt_o       = AMT_W'(insn_i[5:4]);
      end
    end
    dec_o.unpred = dec_o.match && (dec_o.rm == 4'hF);
  end
endmodule

// File: rtl/pfx_shift.sv
module pfx_shift
  import pfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  shift_op_e         op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [2*DATA_W-1:0] dbl;
  logic [AMT_W-2:0]    rot;

  assign dbl = {data_i, data_i};
  assign rot = amt_i[AMT_W-2:0];

  always_comb begin
    unique case (op_i)
      SH_LSL:  data_o = (amt_i >= FULL) ? '0 : (data_i << amt_i);
      SH_LSR:  data_o = (amt_i >= FULL) ? '0 : (data_i >> amt_i);
      SH_ASR:  data_o = (amt_i >= FULL) ? {DATA_W{data_i[DATA_W-1]}}
                                        : DATA_W'($signed(data_i) >>> amt_i);
      SH_ROR:  data_o = dbl[rot +: DATA_W];
      SH_RRX:  data_o = {carry_i, data_i[DATA_W-1:1]};
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/pfx_addsub.sv
module pfx_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  input  logic              add_i,
  output logic [DATA_W-1:0] sum_o
);
  // wraps modulo 2^DATA_W, no overflow indication
  assign sum_o = add_i ? (base_i + off_i) : (base_i - off_i);
endmodule

// File: rtl/pfx_addr_gen.sv
module pfx_addr_gen
  import pfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       insn_i,
  input  logic              narrow_mode_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic              carry_i,
  input  logic              cond_ok_i,
  output logic              hint_vld_o,
  output logic [DATA_W-1:0] target_o,
  output logic              unpred_o,
  output logic              lit_redirect_o
);
  dec_t              dec;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] offset, addr;
  logic              hint_d;

  pfx_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .insn_i        (insn_i),
    .narrow_mode_i (narrow_mode_i),
    .dec_o         (dec),
    .amt_o         (amt)
  );

  pfx_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shf (
    .data_i  (index_i),
    .op_i    (dec.op),
    .amt_i   (amt),
    .carry_i (carry_i),
    .data_o  (offset)
  );

  pfx_addsub #(.DATA_W(DATA_W)) u_add (
    .base_i (base_i),
    .off_i  (offset),
    .add_i  (dec.add),
    .sum_o  (addr)
  );

  assign hint_d = dec.match && !dec.unpred && cond_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hint_vld_o     <= 1'b0;
      target_o       <= '0;
      unpred_o       <= 1'b0;
      lit_redirect_o <= 1'b0;
    end else begin
      hint_vld_o     <= hint_d;
      target_o       <= hint_d ? addr : '0;
      unpred_o       <= dec.unpred;
      lit_redirect_o <= dec.literal;
    end
  end

  AST_HINT_NOT_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_vld_o |-> !lit_redirect_o); // R6
  AST_HINT_NOT_UNPRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_vld_o |-> !unpred_o); // R7
  AST_HINT_NEEDS_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_vld_o |-> $past(cond_ok_i)); // R8
  AST_REDIRECT_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_redirect_o |-> $past(narrow_mode_i)); // R6
  AST_TARGET_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hint_vld_o |-> (target_o == '0)); // R10
endmodule

// File: tb/pfx_addr_gen_test.sv
`timescale 1ns/1ps
module pfx_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn = '0;
  logic        narrow = 1'b0;
  logic [31:0] base = '0, index = '0;
  logic        carry = 1'b0, cond = 1'b0;
  logic        hint, unpred, redir;
  logic [31:0] target;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pfx_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn), .narrow_mode_i(narrow),
    .base_i(base), .index_i(index), .carry_i(carry), .cond_ok_i(cond),
    .hint_vld_o(hint), .target_o(target), .unpred_o(unpred), .lit_redirect_o(redir)
  );

  function automatic logic [31:0] wide_word(logic u, logic [3:0] rn, logic [4:0] a,
                                            logic [1:0] t, logic [3:0] rm);
    return {8'hF6, u, 3'b101, rn, 4'hF, a, t, 1'b0, rm};
  endfunction

  function automatic logic [31:0] narrow_word(logic [3:0] rn, logic [1:0] a, logic [3:0] rm);
    return {12'hF91, rn, 4'hF, 6'd0, a, rm};
  endfunction

  // reference offset from the requirements, 64-bit arithmetic
  function automatic logic [31:0] ref_off(logic [1:0] t, logic [4:0] a, logic c, logic [31:0] x);
    int n;
    logic [63:0] w;
    n = (a == 0 && (t == 2'b01 || t == 2'b10)) ? 32 : int'(a);
    case (t)
      2'b00: w = {32'd0, x} << n;
      2'b01: w = {32'd0, x} >> n;
      2'b10: w = {{32{x[31]}}, x} >> n;
      default: w = (a == 0) ? {32'd0, c, x[31:1]} : ({x, x} >> n);
    endcase
    return w[31:0];
  endfunction

  task automatic apply(logic [31:0] w, logic nm, logic [31:0] b, logic [31:0] ix, logic c,
                       logic co, logic eh, logic [31:0] et, logic eu, logic er, string req);
    @(negedge clk);
    insn = w; narrow = nm; base = b; index = ix; carry = c; cond = co;
    @(negedge clk);
    tests++;
    if (hint !== eh || target !== et || unpred !== eu || redir !== er) begin
      fails++;
      $display("FAIL %s: insn=%h got hint=%b tgt=%h unp=%b red=%b exp hint=%b tgt=%h unp=%b red=%b",
               req, w, hint, target, unpred, redir, eh, et, eu, er);
    end
  endtask

  initial begin
    #(20.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    logic [31:0] idxs  [3];
    bases = '{32'h1000_0000, 32'hFFFF_FFF0, 32'h0000_0004};
    idxs  = '{32'h8000_0013, 32'h0000_0021, 32'hF0F0_1235};

    // R10: reset state
    insn = wide_word(1'b1, 4'd1, 5'd3, 2'b00, 4'd2); cond = 1'b1;
    #15;
    tests++;
    if (hint !== 0 || target !== 0 || unpred !== 0 || redir !== 0) begin
      fails++;
      $display("FAIL R10: reset got %b %h %b %b exp 0 0 0 0", hint, target, unpred, redir);
    end
    @(negedge clk); rst_ni = 1'b1;

    // R1 R2 R3 R4: full sweep of fixed-mode shifts
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        for (int u = 0; u < 2; u++)
          for (int c = 0; c < 2; c++)
            for (int k = 0; k < 3; k++) begin
              logic [31:0] off, exp;
              off = ref_off(2'(t), 5'(a), 1'(c), idxs[k]);
              exp = u ? bases[k] + off : bases[k] - off;
              apply(wide_word(1'(u), 4'(k + 1), 5'(a), 2'(t), 4'(k + 4)), 1'b0, bases[k],
                    idxs[k], 1'(c), 1'b1, 1'b1, exp, 1'b0, 1'b0,
                    t == 3 ? "R3" : (u == 0 ? "R4" : "R2"));
            end

    // R2 corner: shift by 32
    apply(wide_word(1'b1, 4'd0, 5'd0, 2'b01, 4'd1), 1'b0, 32'h5, 32'hFFFF_FFFF, 1'b0, 1'b1,
          1'b1, 32'h5, 1'b0, 1'b0, "R2");
    apply(wide_word(1'b1, 4'd0, 5'd0, 2'b10, 4'd1), 1'b0, 32'h5, 32'h8000_0000, 1'b0, 1'b1,
          1'b1, 32'h4, 1'b0, 1'b0, "R2");
    // R1: bits 15:12 ignored
    apply(wide_word(1'b1, 4'd2, 5'd1, 2'b00, 4'd3) & 32'hFFFF_0FFF, 1'b0, 32'h100, 32'h8,
          1'b0, 1'b1, 1'b1, 32'h110, 1'b0, 1'b0, "R1");

    // R5: mixed-length sweep
    for (int a = 0; a < 4; a++)
      for (int k = 0; k < 3; k++)
        apply(narrow_word(4'(k), 2'(a), 4'(k + 7)), 1'b1, bases[k], idxs[k], 1'b1, 1'b1,
              1'b1, bases[k] + (idxs[k] << a), 1'b0, 1'b0, "R5");

    // R6: literal redirect
    apply(narrow_word(4'hF, 2'd1, 4'd2), 1'b1, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b1, "R6");
    apply(narrow_word(4'hF, 2'd0, 4'd2), 1'b1, 32'h10, 32'h1, 1'b0, 1'b0,
          1'b0, 32'h0, 1'b0, 1'b1, "R6");

    // R7: index 15
    apply(wide_word(1'b1, 4'd2, 5'd1, 2'b00, 4'hF), 1'b0, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b1, 1'b0, "R7");
    apply(narrow_word(4'd2, 2'd1, 4'hF), 1'b1, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b1, 1'b0, "R7");
    apply(narrow_word(4'd2, 2'd1, 4'hF), 1'b1, 32'h10, 32'h1, 1'b0, 1'b0,
          1'b0, 32'h0, 1'b1, 1'b0, "R7");

    // R8: condition failed
    apply(wide_word(1'b1, 4'd2, 5'd1, 2'b00, 4'd3), 1'b0, 32'h10, 32'h1, 1'b0, 1'b0,
          1'b0, 32'h0, 1'b0, 1'b0, "R8");
    apply(narrow_word(4'd2, 2'd3, 4'd3), 1'b1, 32'h10, 32'h1, 1'b0, 1'b0,
          1'b0, 32'h0, 1'b0, 1'b0, "R8");

    // R9: non-matching words
    apply(narrow_word(4'd2, 2'd1, 4'd3), 1'b0, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b0, "R9");
    apply(wide_word(1'b1, 4'd2, 5'd1, 2'b00, 4'd3), 1'b1, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b0, "R9");
    apply(wide_word(1'b1, 4'd2, 5'd1, 2'b00, 4'd3) | 32'h10, 1'b0, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b0, "R9");
    apply(narrow_word(4'd2, 2'd1, 4'hF) | 32'h40, 1'b1, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b0, "R9");
    apply(narrow_word(4'hF, 2'd1, 4'd3) | 32'h800, 1'b1, 32'h10, 32'h1, 1'b0, 1'b1,
          1'b0, 32'h0, 1'b0, 1'b0, "R9");
    apply(32'h0, 1'b0, 32'h10, 32'h1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "R9");

    // R10: outputs return to idle after a hint
    apply(wide_word(1'b0, 4'd2, 5'd2, 2'b00, 4'd3), 1'b0, 32'h0, 32'h1, 1'b0, 1'b1,
          1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 1'b0, 32'h0, 32'h1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule